// File: doc/BRIEF.md
# UART interrupt identification controller

This block decides which interrupt a 16550-style serial port reports. Each cycle it combines the stored interrupt enable bits with the receive status, the receive FIFO fill level against its trigger level, a character-timeout flag and the modem-status change bits. From these it forms the identification byte that software reads and a single interrupt request line. The surrounding port logic provides the status inputs and single-cycle strobes for the register accesses that matter here.

The block keeps one piece of state beyond the enable register: a sticky "transmit holding empty" pending flag, together with the holding-empty and transmitter-empty status bits it depends on. The flag is raised when the transmitter drains or its FIFO is reset. A write to the holding register clears it, and so does a read of the identification byte while that byte names the transmit source. Turning the transmit enable bit on while the holding register is empty arms it again. The identification byte and the request line are registered. Both follow a change of inputs or state after one clock edge.

Top module: `uart_int_id_ctrl`

## Requirements
- R1: After reset the stored enable nibble is 0, the identification byte is 0x01, the request line is low, and the holding-empty and transmitter-empty outputs are both 1.
- R2: Sources are ranked from highest to lowest, with these low-nibble codes: line status 0x6, character timeout 0xC, received data 0x4, transmit holding empty 0x2, modem status 0x0. With no source active the low nibble is 0x1.
- R3: The line-status source is active when enable bit 2 is set and any of status bits 4:1 (break, framing, parity, overrun) is set.
- R4: The character-timeout source is active when enable bit 0 is set and the timeout flag is set. With enable bit 0 clear, the timeout flag has no effect.
- R5: The received-data source is active when enable bit 0 is set, status bit 0 (data ready) is set, and either FIFO mode is off or the receive count is greater than or equal to the trigger level.
- R6: The modem-status source is active when enable bit 3 is set and any of the four delta bits is set.
- R7: Bits 7:6 of the identification byte are 11 while FIFO mode is on and 00 while it is off. Bits 5:4 are always 0.
- R8: A read strobe while the identification byte shows code 0x2 clears the transmit pending flag. A read while it shows any other code leaves the flag unchanged.
- R9: A holding-register write strobe clears the transmit pending flag and drives both the holding-empty and transmitter-empty outputs to 0.
- R10: An enable write that changes bit 1 sets the pending flag if the new bit 1 is 1 and holding-empty is 1, and clears it otherwise. An enable write that leaves bit 1 unchanged does not touch the flag.
- R11: A transmit-FIFO reset strobe sets holding-empty to 1 and sets the pending flag. It leaves transmitter-empty unchanged.
- R12: An enable write stores only bits 3:0 of the 8-bit write data.
- R13: The identification byte and the request line update on the clock edge after their sources change. The request line is high exactly when the low nibble is not 0x1.
- R14: A transmitter-became-empty strobe sets holding-empty, transmitter-empty and the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data (bits 3:0 kept) |
| ier_q | output | 4 | Stored enable bits |
| iir_rd | input | 1 | Identification byte read strobe |
| thr_wr | input | 1 | Holding register write strobe |
| fcr_tx_reset | input | 1 | Transmit FIFO reset strobe |
| tx_became_empty | input | 1 | Transmitter drained strobe |
| line_stat | input | 5 | Bit 0 data ready, bits 4:1 error/break status |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level |
| fifo_en | input | 1 | FIFO mode enabled |
| timeout_pend | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status change bits |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |
| thre | output | 1 | Holding register empty |
| temt | output | 1 | Transmitter empty |

## Verification
The transmit pending flag is the hardest state to reach from the ports. It can only be seen through the identification byte, and only when enable bit 1 is set and no higher source is active. Writing that enable bit can itself re-arm the flag. The directed part of the bench therefore walks fixed strobe sequences: read to clear, rewrite with bit 1 unchanged, toggle bit 1 with holding-empty at 1 and then at 0, and a read while line status masks the transmit code. Each step checks the code. The sweep then sets the flag to a known value before every enable pattern, using a reset or write strobe issued after the enable write. It then covers all line-status, timeout, modem-delta, FIFO-mode and count-against-trigger combinations.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

  localparam logic [3:0] ID_LINE = 4'h6;
  localparam logic [3:0] ID_TMO  = 4'hC;
  localparam logic [3:0] ID_RXD  = 4'h4;
  localparam logic [3:0] ID_THR  = 4'h2;
  localparam logic [3:0] ID_MDM  = 4'h0;
  localparam logic [3:0] ID_NONE = 4'h1;

  typedef struct packed {
    logic line;
    logic tmo;
    logic rxd;
    logic thr;
    logic mdm;
  } src_t;

  // Ranked selection of the reported code
  function automatic logic [3:0] pick_id(input src_t s);
    logic [3:0] id;
    if (s.line)      id = ID_LINE;
    else if (s.tmo)  id = ID_TMO;
    else if (s.rxd)  id = ID_RXD;
    else if (s.thr)  id = ID_THR;
    else if (s.mdm)  id = ID_MDM;
    else             id = ID_NONE;
    return id;
  endfunction

  function automatic logic [7:0] make_iir(input logic fifo_on, input logic [3:0] id);
    return {fifo_on, fifo_on, 2'b00, id};
  endfunction

endpackage

// File: rtl/uart_ier_reg.sv
module uart_ier_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_wr,
  input  logic [7:0] ier_wdata,
  output logic [3:0] ier_q,
  output logic       thri_edit,
  output logic       thri_new
);
  logic unused_hi;
  assign unused_hi = ^ier_wdata[7:4];

  assign thri_edit = ier_wr && (ier_wdata[1] != ier_q[1]);
  assign thri_new  = ier_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ier_q <= 4'h0;
    else if (ier_wr) ier_q <= ier_wdata[3:0];
  end
endmodule

// File: rtl/uart_thre_track.sv
module uart_thre_track (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_wr,
  input  logic fcr_tx_reset,
  input  logic tx_became_empty,
  input  logic iir_rd,
  input  logic iir_shows_thr,
  input  logic thri_edit,
  input  logic thri_new,
  output logic thre,
  output logic temt,
  output logic thr_pend
);
  logic pend_n, thre_n, temt_n;

  // Later events in this list win when strobes coincide
  always_comb begin
    pend_n = thr_pend;
    thre_n = thre;
    temt_n = temt;
    if (tx_became_empty) begin
      thre_n = 1'b1;
      temt_n = 1'b1;
      pend_n = 1'b1;
    end
    if (iir_rd && iir_shows_thr) pend_n = 1'b0;
    if (thri_edit) pend_n = thri_new && thre;
    if (thr_wr) begin
      pend_n = 1'b0;
      thre_n = 1'b0;
      temt_n = 1'b0;
    end
    if (fcr_tx_reset) begin
      thre_n = 1'b1;
      pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre     <= 1'b1;
      temt     <= 1'b1;
      thr_pend <= 1'b0;
    end else begin
      thre     <= thre_n;
      temt     <= temt_n;
      thr_pend <= pend_n;
    end
  end
endmodule

// File: rtl/uart_iir_prio.sv
module uart_iir_prio
  import uart_iid_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ier_q,
  input  logic [4:0]       line_stat,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             fifo_en,
  input  logic             timeout_pend,
  input  logic [3:0]       msr_delta,
  input  logic             thr_pend,
  output logic [7:0]       iir_q,
  output logic             irq
);
  src_t       src;
  logic       level_met;
  logic [3:0] id_next;

  assign level_met = !fifo_en || (rx_count >= rx_trig);

  assign src.line = ier_q[2] && (|line_stat[4:1]);
  assign src.tmo  = ier_q[0] && timeout_pend;
  assign src.rxd  = ier_q[0] && line_stat[0] && level_met;
  assign src.thr  = ier_q[1] && thr_pend;
  assign src.mdm  = ier_q[3] && (|msr_delta);

  assign id_next = pick_id(src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir_q <= make_iir(1'b0, ID_NONE);
      irq   <= 1'b0;
    end else begin
      iir_q <= make_iir(fifo_en, id_next);
      irq   <= (id_next != ID_NONE);
    end
  end
endmodule

// File: rtl/uart_int_id_ctrl.sv
module uart_int_id_ctrl
  import uart_iid_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  output logic [3:0]       ier_q,
  input  logic             iir_rd,
  input  logic             thr_wr,
  input  logic             fcr_tx_reset,
  input  logic             tx_became_empty,
  input  logic [4:0]       line_stat,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             fifo_en,
  input  logic             timeout_pend,
  input  logic [3:0]       msr_delta,
  output logic [7:0]       iir,
  output logic             irq,
  output logic             thre,
  output logic             temt
);
  logic thri_edit, thri_new, thr_pend, iir_shows_thr;

  assign iir_shows_thr = (iir[3:0] == ID_THR);

  uart_ier_reg i_ier (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .ier_q(ier_q), .thri_edit(thri_edit), .thri_new(thri_new)
  );

  uart_thre_track i_thre (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .fcr_tx_reset(fcr_tx_reset),
    .tx_became_empty(tx_became_empty), .iir_rd(iir_rd),
    .iir_shows_thr(iir_shows_thr), .thri_edit(thri_edit), .thri_new(thri_new),
    .thre(thre), .temt(temt), .thr_pend(thr_pend)
  );

  uart_iir_prio #(.CNT_W(CNT_W)) i_prio (
    .clk(clk), .rst_n(rst_n), .ier_q(ier_q), .line_stat(line_stat),
    .rx_count(rx_count), .rx_trig(rx_trig), .fifo_en(fifo_en),
    .timeout_pend(timeout_pend), .msr_delta(msr_delta), .thr_pend(thr_pend),
    .iir_q(iir), .irq(irq)
  );
endmodule

// File: rtl/uart_int_id_chk.sv
module uart_int_id_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_wr,
  input logic [7:0] ier_wdata,
  input logic [3:0] ier_q,
  input logic       iir_rd,
  input logic       thr_wr,
  input logic       fcr_tx_reset,
  input logic       tx_became_empty,
  input logic [4:0] line_stat,
  input logic       fifo_en,
  input logic [7:0] iir,
  input logic       irq,
  input logic       thre,
  input logic       temt,
  input logic       thr_pend
);
  assert_irq_nibble_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir[3:0] != 4'h1));

  assert_line_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[2] && (|line_stat[4:1])) |=> (iir[3:0] == 4'h6));

  assert_fifo_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (iir[7:6] == {2{$past(fifo_en)}}) && (iir[5:4] == 2'b00));

  assert_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir[3:0] == 4'h2 && !fcr_tx_reset && !tx_became_empty &&
     !(ier_wr && (ier_wdata[1] != ier_q[1]))) |=> !thr_pend);

  assert_thr_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !fcr_tx_reset) |=> (!thre && !temt && !thr_pend));

  assert_fcr_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_tx_reset |=> (thre && thr_pend && $stable(temt)));

  assert_ier_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> (ier_q == $past(ier_wdata[3:0])));

  assert_drain_set_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_became_empty && !thr_wr) |=> (thre && temt));
endmodule

bind uart_int_id_ctrl uart_int_id_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
  .ier_q(ier_q), .iir_rd(iir_rd), .thr_wr(thr_wr), .fcr_tx_reset(fcr_tx_reset),
  .tx_became_empty(tx_became_empty), .line_stat(line_stat), .fifo_en(fifo_en),
  .iir(iir), .irq(irq), .thre(thre), .temt(temt), .thr_pend(thr_pend)
);

// File: tb/test_uart_int_id_ctrl.sv
module test_uart_int_id_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ier_wr = 1'b0;
  logic [7:0]    ier_wdata = 8'h00;
  logic [3:0]    ier_q;
  logic          iir_rd = 1'b0, thr_wr = 1'b0, fcr_tx_reset = 1'b0, tx_became_empty = 1'b0;
  logic [4:0]    line_stat = 5'h0;
  logic [CW-1:0] rx_count = '0, rx_trig = '0;
  logic          fifo_en = 1'b0, timeout_pend = 1'b0;
  logic [3:0]    msr_delta = 4'h0;
  logic [7:0]    iir;
  logic          irq, thre, temt;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_int_id_ctrl #(.CNT_W(CW)) i_uart_int_id_ctrl (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_q(ier_q),
    .iir_rd(iir_rd), .thr_wr(thr_wr), .fcr_tx_reset(fcr_tx_reset),
    .tx_became_empty(tx_became_empty), .line_stat(line_stat), .rx_count(rx_count),
    .rx_trig(rx_trig), .fifo_en(fifo_en), .timeout_pend(timeout_pend),
    .msr_delta(msr_delta), .iir(iir), .irq(irq), .thre(thre), .temt(temt)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wr = 1'b1; ier_wdata = v;
    @(negedge clk);
    ier_wr = 1'b0;
  endtask

  // 0 read, 1 holding write, 2 fifo reset, 3 drained
  task automatic strobe(input int which);
    case (which)
      0: iir_rd = 1'b1;
      1: thr_wr = 1'b1;
      2: fcr_tx_reset = 1'b1;
      default: tx_became_empty = 1'b1;
    endcase
    @(negedge clk);
    iir_rd = 1'b0; thr_wr = 1'b0; fcr_tx_reset = 1'b0; tx_became_empty = 1'b0;
  endtask

  function automatic logic [3:0] ref_code(input logic [3:0] en, input logic [4:0] ls,
      input logic tmo, input logic [3:0] md, input logic fe, input int cnt, input int trg,
      input logic pend);
    logic [3:0] c;
    c = 4'h1;
    if (en[3] && md != 4'h0)                      c = 4'h0;
    if (en[1] && pend)                            c = 4'h2;
    if (en[0] && ls[0] && (!fe || cnt >= trg))    c = 4'h4;
    if (en[0] && tmo)                             c = 4'hC;
    if (en[2] && ls[4:1] != 4'h0)                 c = 4'h6;
    return c;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] ec;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 iir", iir, 8'h01);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 ier", {4'b0, ier_q}, 8'h00);
    chk("R1 thre/temt", {6'b0, thre, temt}, 8'h03);

    // R12 only low nibble kept
    wr_ier(8'hF5);
    chk("R12 ier", {4'b0, ier_q}, 8'h05);
    wr_ier(8'h00);

    // R10 enabling bit 1 with THRE=1 arms the flag
    wr_ier(8'h02); @(negedge clk);
    chk("R10 arm", iir, 8'h02);
    chk("R13 irq high", {7'b0, irq}, 8'h01);
    // R8 read while code 2 clears
    strobe(0); @(negedge clk);
    chk("R8 read clear", iir, 8'h01);
    chk("R13 irq low", {7'b0, irq}, 8'h00);
    // R10 unchanged bit 1: no rearm
    wr_ier(8'h02); @(negedge clk);
    chk("R10 same bit", iir, 8'h01);
    wr_ier(8'h00); wr_ier(8'h02); @(negedge clk);
    chk("R10 toggle rearm", iir, 8'h02);
    // R9 holding write
    strobe(1); @(negedge clk);
    chk("R9 iir", iir, 8'h01);
    chk("R9 thre/temt", {6'b0, thre, temt}, 8'h00);
    // R10 toggle with THRE=0 clears
    wr_ier(8'h00); wr_ier(8'h02); @(negedge clk);
    chk("R10 thre low", iir, 8'h01);
    // R14 drained
    strobe(3); @(negedge clk);
    chk("R14 iir", iir, 8'h02);
    chk("R14 thre/temt", {6'b0, thre, temt}, 8'h03);
    strobe(0); @(negedge clk);
    chk("R8 clear again", iir, 8'h01);
    // R11 fifo reset
    strobe(1); strobe(2); @(negedge clk);
    chk("R11 iir", iir, 8'h02);
    chk("R11 thre/temt", {6'b0, thre, temt}, 8'h02);
    // R8 read while a higher source shows: flag kept
    wr_ier(8'h06);
    line_stat = 5'b00010; @(negedge clk);
    chk("R3 line code", iir, 8'h06);
    strobe(0);
    line_stat = 5'b00000; @(negedge clk);
    chk("R8 masked read kept", iir, 8'h02);
    // R7 fifo bits
    wr_ier(8'h00); fifo_en = 1'b1; @(negedge clk);
    chk("R7 fifo on", iir, 8'hC1);
    fifo_en = 1'b0; @(negedge clk);
    chk("R7 fifo off", iir, 8'h01);

    // Sweep: R2 R3 R4 R5 R6 R7 R13
    rx_trig = CW'(8);
    for (int en = 0; en < 16; en++) begin
      for (int pd = 0; pd < 2; pd++) begin
        line_stat = '0; timeout_pend = 1'b0; msr_delta = '0; fifo_en = 1'b0;
        wr_ier(8'(en));
        strobe(pd == 1 ? 2 : 1);
        for (int lv = 0; lv < 32; lv++)
          for (int tm = 0; tm < 2; tm++)
            for (int mm = 0; mm < 2; mm++)
              for (int fe = 0; fe < 2; fe++)
                for (int cc = 0; cc < 3; cc++) begin
                  line_stat = 5'(lv);
                  timeout_pend = tm[0];
                  msr_delta = (mm == 1) ? (4'b0001 << (lv % 4)) : 4'b0000;
                  fifo_en = fe[0];
                  rx_count = CW'(7 + cc);
                  @(negedge clk);
                  ec = ref_code(4'(en), 5'(lv), tm[0], msr_delta, fe[0], 7 + cc, 8, pd[0]);
                  chk("R2 R3 R4 R5 R6 R7 sweep iir", iir, {fe[0], fe[0], 2'b00, ec});
                  chk("R13 sweep irq", {7'b0, irq}, {7'b0, ec != 4'h1});
                end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule